// File: doc/BRIEF.md
# Dual-Channel UART Transmit Queue Ready Logic

This block produces the transmit-side readiness indications for a pair of UART channels. Each channel keeps an occupancy counter for its 64-entry transmit queue, advanced by push and pop strobes. The counter is compared against an effective trigger level built from a coarse two-bit setting and a fine six-bit level, and the result drives three indications per channel: a DMA-request pin, a status bit packed into a shared ready register, and the transmitter-empty line-status bit.

The pin and the register bit use the same threshold but behave differently. In block DMA mode the active-low pin latches with hysteresis: it asserts once enough free spaces exist and deasserts only when the queue becomes completely full, holding its state in between. The register bit never latches; it is a live comparison of the current free-space count against the threshold. Software can poll the ready register for a coarse view of both channels in one read, while a DMA engine uses the pin to move bursts.

Top module: `uart_txq_ready_pair`

## Requirements
- R1: Each channel's occupancy count starts at 0 after reset, increments on push, decrements on pop, ignores a push when at 64 and a pop when at 0, and stays unchanged when push and pop arrive together; it is visible on `fill_count_o` (channel n in bits [7n+6:7n]).
- R2: The effective trigger equals the fine level when that is nonzero, otherwise 16 times the coarse code (codes 0..3 give 0, 16, 32, 48); an effective value of 0 is used as 1.
- R3: Ready-register bit 0 (channel A) and bit 1 (channel B) are 1 exactly when free spaces (64 minus occupancy) are at least the effective trigger, following the current count and trigger without any latching.
- R4: Ready-register bits 7 down to 2 always read 0.
- R5: With block DMA mode set, `txrdy_n_o` for a channel is driven low whenever free spaces are at least the effective trigger.
- R6: With block DMA mode set, `txrdy_n_o` is driven high whenever the queue holds 64 entries.
- R7: With block DMA mode set and the queue neither full nor at the threshold, `txrdy_n_o` keeps the value it had in the previous cycle.
- R8: With block DMA mode clear, `txrdy_n_o` is the inverse of that channel's ready-register bit.
- R9: `temt_o` for a channel is 1 only when the occupancy is 0 and that channel's shift-register-empty input is 1.
- R10: After reset both pins are low (active) and the internal hysteresis state is in the ready state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_i | input | 2 | Per-channel enqueue strobe |
| pop_i | input | 2 | Per-channel dequeue strobe |
| shift_empty_i | input | 2 | Per-channel transmit shift register is empty |
| block_dma_i | input | 2 | Per-channel block DMA mode select |
| coarse_sel_i | input | 4 | Per-channel coarse trigger code, 2 bits each |
| fine_lvl_i | input | 12 | Per-channel fine trigger level, 6 bits each |
| fill_count_o | output | 14 | Per-channel occupancy, 7 bits each |
| txrdy_n_o | output | 2 | Per-channel active-low DMA transmit-ready pin |
| temt_o | output | 2 | Per-channel transmitter-empty status |
| ready_reg_o | output | 8 | Packed live ready bits, upper bits zero |

## Verification
The assertions assume the strobes and configuration fields are stable across each rising edge and that trigger fields change only between edges, so the hysteresis state sampled at one edge reflects the configuration seen by the comparator in the preceding cycle. The stimulus drives every input on the falling edge, fills each queue one entry at a time past full and drains it past empty, and sweeps all coarse codes plus fine levels 1, 52 and 63 in both DMA modes. Simultaneous push and pop at mid-level and toggling of the shift-empty inputs keep every input combination inside that timing contract.

// File: rtl/uart_txq_ready_pkg.sv
package uart_txq_ready_pkg;
  typedef enum logic [1:0] {
    OCC_HOLD = 2'b00,
    OCC_INC  = 2'b01,
    OCC_DEC  = 2'b10
  } occ_op_e;
endpackage

// File: rtl/txq_occupancy.sv
module txq_occupancy
  import uart_txq_ready_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic             pop_i,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  occ_op_e          op;

  always_comb begin
    op = OCC_HOLD;
    if (push_i && !pop_i && (cnt_q != FULL_CNT)) op = OCC_INC;
    else if (pop_i && !push_i && (cnt_q != '0))  op = OCC_DEC;
  end

  always_comb begin
    cnt_en = (op != OCC_HOLD);
    unique case (op)
      OCC_INC: cnt_d = cnt_q + 1'b1;
      OCC_DEC: cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;

  assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL_CNT);
  assert_full_push_held_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == FULL_CNT && push_i && !pop_i) |=> (cnt_q == FULL_CNT));
  assert_empty_pop_held_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && pop_i && !push_i) |=> (cnt_q == '0));
  assert_both_strobes_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && pop_i) |=> $stable(cnt_q));
endmodule

// File: rtl/txq_trigger_sel.sv
module txq_trigger_sel #(
  parameter int DEPTH       = 64,
  parameter int CNT_W       = $clog2(DEPTH + 1),
  parameter int COARSE_W    = 2,
  parameter int FINE_W      = $clog2(DEPTH),
  parameter int COARSE_STEP = 16
) (
  input  logic [COARSE_W-1:0] coarse_i,
  input  logic [FINE_W-1:0]   fine_i,
  output logic [CNT_W-1:0]    trig_o
);
  logic [CNT_W-1:0] coarse_lvl, raw_lvl;

  always_comb begin
    coarse_lvl = CNT_W'(coarse_i) * CNT_W'(COARSE_STEP);
    raw_lvl    = (fine_i != '0) ? CNT_W'(fine_i) : coarse_lvl;
    trig_o     = (raw_lvl == '0) ? CNT_W'(1) : raw_lvl;
  end

  always_comb begin
    assert_trig_nonzero_R2: assert (trig_o != '0);
  end
endmodule

// File: rtl/txq_ready_eval.sv
module txq_ready_eval #(
  parameter int DEPTH = 64,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count_i,
  input  logic [CNT_W-1:0] trig_i,
  input  logic             block_i,
  output logic             status_o,
  output logic             active_o
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [CNT_W-1:0] free_sp;
  logic             meets, full;
  logic             act_q, act_d;

  always_comb begin
    free_sp = FULL_CNT - count_i;
    meets   = (free_sp >= trig_i);
    full    = (count_i == FULL_CNT);
  end

  always_comb begin
    if (!block_i)   act_d = meets;
    else if (full)  act_d = 1'b0;
    else if (meets) act_d = 1'b1;
    else            act_d = act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= 1'b1;
    else        act_q <= act_d;
  end

  assign status_o = meets;
  assign active_o = act_d;

  assert_meets_active_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (block_i && meets) |-> active_o);
  assert_full_inactive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (block_i && full) |-> !active_o);
  assert_hold_on_R7: assert property (@(posedge clk) disable iff (!rst_n)
    active_o |=> (!block_i || full || active_o));
  assert_hold_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !active_o |=> (!block_i || meets || !active_o));
endmodule

// File: rtl/uart_txq_ready_pair.sv
module uart_txq_ready_pair #(
  parameter int DEPTH       = 64,
  parameter int NCH         = 2,
  parameter int REG_W       = 8,
  parameter int COARSE_W    = 2,
  parameter int COARSE_STEP = 16,
  parameter int FINE_W      = $clog2(DEPTH),
  parameter int CNT_W       = $clog2(DEPTH + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NCH-1:0]          push_i,
  input  logic [NCH-1:0]          pop_i,
  input  logic [NCH-1:0]          shift_empty_i,
  input  logic [NCH-1:0]          block_dma_i,
  input  logic [NCH*COARSE_W-1:0] coarse_sel_i,
  input  logic [NCH*FINE_W-1:0]   fine_lvl_i,
  output logic [NCH*CNT_W-1:0]    fill_count_o,
  output logic [NCH-1:0]          txrdy_n_o,
  output logic [NCH-1:0]          temt_o,
  output logic [REG_W-1:0]        ready_reg_o
);
  logic [NCH-1:0] status;
  logic [NCH-1:0] active;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] trig;

    txq_occupancy #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_occ (
      .clk     (clk),
      .rst_n   (rst_n),
      .push_i  (push_i[ch]),
      .pop_i   (pop_i[ch]),
      .count_o (cnt)
    );

    txq_trigger_sel #(
      .DEPTH(DEPTH), .CNT_W(CNT_W), .COARSE_W(COARSE_W),
      .FINE_W(FINE_W), .COARSE_STEP(COARSE_STEP)
    ) u_trig (
      .coarse_i (coarse_sel_i[ch*COARSE_W +: COARSE_W]),
      .fine_i   (fine_lvl_i[ch*FINE_W +: FINE_W]),
      .trig_o   (trig)
    );

    txq_ready_eval #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_rdy (
      .clk      (clk),
      .rst_n    (rst_n),
      .count_i  (cnt),
      .trig_i   (trig),
      .block_i  (block_dma_i[ch]),
      .status_o (status[ch]),
      .active_o (active[ch])
    );

    assign fill_count_o[ch*CNT_W +: CNT_W] = cnt;
    assign temt_o[ch]    = (cnt == '0) && shift_empty_i[ch];
    assign txrdy_n_o[ch] = ~active[ch];

    assert_plain_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !block_dma_i[ch] |-> (txrdy_n_o[ch] == !ready_reg_o[ch]));
    assert_temt_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
      temt_o[ch] |-> (fill_count_o[ch*CNT_W +: CNT_W] == '0));
  end

  always_comb begin
    ready_reg_o = '0;
    ready_reg_o[NCH-1:0] = status;
  end

  assert_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ready_reg_o[REG_W-1:NCH] == '0);
endmodule

// File: tb/sim_uart_txq_ready_pair.sv
`timescale 1ns/1ps
module sim_uart_txq_ready_pair;
  localparam int DEPTH = 64;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  push, pop, sh_empty, blk;
  logic [3:0]  coarse;
  logic [11:0] fine;
  logic [13:0] fill;
  logic [1:0]  txrdy_n, temt;
  logic [7:0]  rreg;

  int n_tests = 0;
  int n_fail  = 0;
  int m_cnt   [2];
  bit m_latch [2];

  always #2.5 clk = ~clk;

  uart_txq_ready_pair u0 (
    .clk(clk), .rst_n(rst_n), .push_i(push), .pop_i(pop),
    .shift_empty_i(sh_empty), .block_dma_i(blk), .coarse_sel_i(coarse),
    .fine_lvl_i(fine), .fill_count_o(fill), .txrdy_n_o(txrdy_n),
    .temt_o(temt), .ready_reg_o(rreg)
  );

  function automatic int eff_trig(int ch);
    int c, f, t;
    c = int'(coarse[ch*2 +: 2]);
    f = int'(fine[ch*6 +: 6]);
    t = (f != 0) ? f : c * 16;
    if (t == 0) t = 1;
    return t;
  endfunction

  function automatic bit m_active(int ch);
    bit meets;
    meets = (DEPTH - m_cnt[ch]) >= eff_trig(ch);
    if (!blk[ch])                 return meets;
    if (m_cnt[ch] == DEPTH)       return 1'b0;
    if (meets)                    return 1'b1;
    return m_latch[ch];
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    for (int ch = 0; ch < 2; ch++) begin
      bit meets;
      meets = (DEPTH - m_cnt[ch]) >= eff_trig(ch);
      chk("R1 count", int'(fill[ch*7 +: 7]), m_cnt[ch]);
      chk("R3 ready bit", int'(rreg[ch]), int'(meets));
      if (blk[ch]) chk("R5/R6/R7 block pin", int'(txrdy_n[ch]), int'(!m_active(ch)));
      else         chk("R8 plain pin", int'(txrdy_n[ch]), int'(!meets));
      chk("R9 temt", int'(temt[ch]), int'(m_cnt[ch] == 0 && sh_empty[ch]));
    end
    chk("R4 upper bits", int'(rreg[7:2]), 0);
  endtask

  task automatic step(bit [1:0] pu, bit [1:0] po);
    bit nl [2];
    push = pu; pop = po;
    for (int ch = 0; ch < 2; ch++) nl[ch] = m_active(ch);
    @(posedge clk);
    for (int ch = 0; ch < 2; ch++) begin
      m_latch[ch] = nl[ch];
      if (pu[ch] && !po[ch] && m_cnt[ch] < DEPTH) m_cnt[ch]++;
      else if (po[ch] && !pu[ch] && m_cnt[ch] > 0) m_cnt[ch]--;
    end
    @(negedge clk);
    push = '0; pop = '0;
    check_all();
  endtask

  task automatic run_cfg(bit [1:0] b, bit [3:0] c, bit [11:0] f);
    blk = b; coarse = c; fine = f;
    #0.1;
    check_all();
    for (int i = 0; i < DEPTH + 2; i++) begin
      sh_empty = 2'(i % 3);
      step(2'b01, 2'b10);
    end
    for (int i = 0; i < 4; i++) step(2'b11, 2'b11);
    for (int i = 0; i < DEPTH + 2; i++) step(2'b10, 2'b01);
    for (int i = 0; i < 12; i++) step(2'b00, 2'b11);
    for (int i = 0; i < 6; i++) step(2'b11, 2'b00);
  endtask

  initial begin
    #100000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; push = '0; pop = '0; sh_empty = 2'b11;
    blk = 2'b11; coarse = 4'b1110; fine = '0;
    for (int ch = 0; ch < 2; ch++) begin m_cnt[ch] = 0; m_latch[ch] = 1'b1; end
    repeat (3) @(negedge clk);
    check_all();
    chk("R10 reset pins low", int'(txrdy_n), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check_all();
    // R2: every coarse code with fine zero, then fine levels overriding
    run_cfg(2'b11, {2'd3, 2'd0}, {6'd0, 6'd0});
    run_cfg(2'b11, {2'd1, 2'd2}, {6'd0, 6'd0});
    run_cfg(2'b11, {2'd0, 2'd3}, {6'd52, 6'd52});
    run_cfg(2'b11, {2'd2, 2'd1}, {6'd1, 6'd63});
    run_cfg(2'b01, {2'd0, 2'd3}, {6'd52, 6'd0});
    run_cfg(2'b10, {2'd2, 2'd2}, {6'd0, 6'd52});
    run_cfg(2'b00, {2'd1, 2'd0}, {6'd63, 6'd0});
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule